// File: doc/BRIEF.md
# Data-Side Victim Buffer

This block keeps a small, fully associative store of lines that the data cache has recently thrown out, and sits on the path between that cache and main memory. When the data cache misses, it presents the missing line address here together with the line it is about to evict. If the missing line is held here, the block hands it back after a short fixed delay. The evicted line takes over the freed slot, so two lines that keep colliding in one cache set trade places here instead of each trip going out to memory.

On a miss the block issues a read to memory and relays the returned line. The evicted line, clean or dirty, is kept for later reuse. If the store is full, the entry written longest ago is pushed out: a dirty one goes to memory on a one-cycle write-back pulse, and a clean one is dropped. Each entry is a multi-word line with its own address, dirty flag and valid bit. Requests are taken one at a time. The cache waits for the ready signal before it presents the next one.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is invalid, so the first lookup of any address misses. While reset is held and in the first idle cycle, `lk_ready` is 1 and `rsp_valid`, `mem_rd_req` and `wb_valid` are 0.
- R2: A lookup hits only when a valid entry holds exactly the same full line address. An address that differs in any bit, the top bit included, misses.
- R3: A hit taken in cycle 0 (the cycle ending at the accepting edge) drives `rsp_valid` in cycle HIT_LAT with `rsp_hit`=1, the stored line and that line's dirty flag. It raises neither `mem_rd_req` nor `wb_valid`.
- R4: On a hit with `ev_valid`=1, the evicted line, its address and its dirty flag replace the hit entry. A later lookup of the evicted address hits with that data and flag, and the line that was handed out now misses.
- R5: A miss accepted in cycle 0 raises `mem_rd_req` for exactly cycle 1 with `mem_rd_addr` equal to the lookup address. The cycle after `mem_rd_valid` it drives `rsp_valid` with `rsp_hit`=0, `rsp_dirty`=0 and the memory data.
- R6: On a miss with `ev_valid`=1, the evicted line is stored whether it is clean or dirty. If there is a free slot it goes into the lowest-numbered free slot, with no write-back.
- R7: On a miss with `ev_valid`=1 and no free slot, the entry written longest ago is replaced. If that entry was dirty, `wb_valid` is 1 for exactly cycle 1 and carries its address and data. If it was clean, `wb_valid` stays 0.
- R8: Any write into a slot, by insertion or by swap, makes that slot the most recently written. Age order counts writes only, never lookups.
- R9: `lk_ready` is 0 from the cycle after acceptance through the response cycle and is 1 again the cycle after. A lookup presented while `lk_ready` is 0 is ignored. It produces no response and changes no entry.
- R10: A hit with `ev_valid`=0 frees the hit slot, so the next lookup of that address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request from the data cache after a miss |
| lk_ready | output | 1 | Block is idle and takes a lookup this cycle |
| lk_addr | input | LINE_AW | Line address that missed in the data cache |
| ev_valid | input | 1 | An evicted line comes with the lookup |
| ev_addr | input | LINE_AW | Line address of the evicted line |
| ev_dirty | input | 1 | Evicted line is modified |
| ev_data | input | WORDS*DATA_W | Evicted line data |
| rsp_valid | output | 1 | Response line is valid this cycle |
| rsp_hit | output | 1 | Response came from this block, not memory |
| rsp_dirty | output | 1 | Returned line is modified |
| rsp_data | output | WORDS*DATA_W | Returned line data |
| mem_rd_req | output | 1 | One-cycle memory line read request |
| mem_rd_addr | output | LINE_AW | Line address to read |
| mem_rd_valid | input | 1 | Memory read data is valid |
| mem_rd_data | input | WORDS*DATA_W | Memory read data |
| wb_valid | output | 1 | One-cycle write-back of a displaced dirty line |
| wb_addr | output | LINE_AW | Write-back line address |
| wb_data | output | WORDS*DATA_W | Write-back line data |

## Verification
The bench builds the block with its default parameters: 4 entries of two 32-bit words, 28-bit line addresses and a hit latency of 4. With only four slots, a handful of directed lookups reaches the full state, where the age order decides which entry is replaced. The bench also steers dirty and clean lines into that oldest slot, so both the write-back and the silent drop are seen. With a latency of 4 and a memory model that answers in 6 cycles, hit and miss responses arrive at clearly different times, so the exact hit timing can be checked. A seeded run over a pool of twelve addresses then mixes swaps, refills and displacements in ways the directed cases do not cover.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // Control phases of the victim buffer.
  typedef enum logic [1:0] {
    VC_IDLE      = 2'd0,
    VC_HIT_WAIT  = 2'd1,
    VC_MISS_WAIT = 2'd2,
    VC_RESP      = 2'd3
  } vc_state_e;

endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int ENTRIES = 4,
  parameter int AW      = 28,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ENTRIES-1:0]          ent_valid,
  input  logic [ENTRIES-1:0][AW-1:0]  ent_addr,
  input  logic [AW-1:0]               key,
  output logic                        hit,
  output logic [IW-1:0]               hit_idx
);

  logic [ENTRIES-1:0] match_vec;

  // One full-width comparator per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = ent_valid[g] && (ent_addr[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IW'(i);
    end
  end

  assign hit = |match_vec;

  // The store never holds one address twice.
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)) else $error("duplicate address match"); // R2

endmodule

// File: rtl/vc_age.sv
module vc_age #(
  parameter int ENTRIES = 4,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                touch,
  input  logic [IW-1:0]       touch_idx,
  input  logic [ENTRIES-1:0]  ent_valid,
  output logic [IW-1:0]       vict_idx,
  output logic                vict_free
);

  localparam logic [IW-1:0] AGE_MAX = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0][IW-1:0] age_q, age_d;
  logic [ENTRIES-1:0]         oldest_vec;
  logic [IW-1:0]              oldest_idx;
  logic [IW-1:0]              free_idx;

  // Ages form a permutation; a touched slot becomes age 0 and the
  // slots that were younger than it move one step older.
  always_comb begin
    age_d = age_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (IW'(i) == touch_idx) begin
        age_d[i] = '0;
      end else if (age_q[i] < age_q[touch_idx]) begin
        age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IW'(ENTRIES - 1 - i);
    end else if (touch) begin
      age_q <= age_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign oldest_vec[g] = (age_q[g] == AGE_MAX);
  end

  always_comb begin
    oldest_idx = '0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (oldest_vec[i]) oldest_idx = IW'(i);
      if (!ent_valid[i]) free_idx   = IW'(i);
    end
  end

  assign vict_free = ~&ent_valid;
  assign vict_idx  = vict_free ? free_idx : oldest_idx;

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1) else $error("age order broken"); // R7

  AST_TOUCH_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> (age_q[$past(touch_idx)] == '0)) else $error("touched slot not youngest"); // R8

endmodule

// File: rtl/vc_store.sv
module vc_store #(
  parameter int ENTRIES = 4,
  parameter int AW      = 28,
  parameter int LW      = 64,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IW-1:0]               wr_idx,
  input  logic [AW-1:0]               wr_addr,
  input  logic [LW-1:0]               wr_data,
  input  logic                        wr_dirty,
  input  logic                        clr_en,
  input  logic [IW-1:0]               clr_idx,
  output logic [ENTRIES-1:0]          ent_valid,
  output logic [ENTRIES-1:0][AW-1:0]  ent_addr,
  output logic [ENTRIES-1:0][LW-1:0]  ent_data,
  output logic [ENTRIES-1:0]          ent_dirty
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel_wr, sel_clr;
    assign sel_wr  = wr_en  && (wr_idx  == IW'(g));
    assign sel_clr = clr_en && (clr_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
      end else if (sel_wr) begin
        ent_valid[g] <= 1'b1;
      end else if (sel_clr) begin
        ent_valid[g] <= 1'b0;
      end
    end

    // Payload carries no reset; the valid bit qualifies it.
    always_ff @(posedge clk) begin
      if (sel_wr) begin
        ent_addr[g]  <= wr_addr;
        ent_data[g]  <= wr_data;
        ent_dirty[g] <= wr_dirty;
      end
    end
  end

  AST_WR_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr_en)) else $error("write and clear together"); // R10

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !ent_valid[$past(clr_idx)]) else $error("cleared slot still valid"); // R10

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 2,
  parameter int DATA_W  = 32,
  parameter int LINE_AW = 28,
  parameter int HIT_LAT = 4,
  localparam int LW     = WORDS * DATA_W,
  localparam int IW     = $clog2(ENTRIES),
  localparam int CW     = $clog2(HIT_LAT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [LINE_AW-1:0] lk_addr,
  input  logic               ev_valid,
  input  logic [LINE_AW-1:0] ev_addr,
  input  logic               ev_dirty,
  input  logic [LW-1:0]      ev_data,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_dirty,
  output logic [LW-1:0]      rsp_data,
  output logic               mem_rd_req,
  output logic [LINE_AW-1:0] mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [LW-1:0]      mem_rd_data,
  output logic               wb_valid,
  output logic [LINE_AW-1:0] wb_addr,
  output logic [LW-1:0]      wb_data
);

  import vc_pkg::*;

  // Store view
  logic [ENTRIES-1:0]              ent_valid;
  logic [ENTRIES-1:0][LINE_AW-1:0] ent_addr;
  logic [ENTRIES-1:0][LW-1:0]      ent_data;
  logic [ENTRIES-1:0]              ent_dirty;

  logic            hit;
  logic [IW-1:0]   hit_idx;
  logic [IW-1:0]   vict_idx;
  logic            vict_free;

  // Store and age controls
  logic            st_wr_en, st_clr_en, touch;
  logic [IW-1:0]   st_wr_idx, st_clr_idx, touch_idx;

  // Control state
  vc_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            accept;

  // Response, request and write-back registers
  logic               rsp_ld;
  logic [LW-1:0]      rsp_line_q, rsp_line_d;
  logic               rsp_dirty_q, rsp_dirty_d;
  logic               rsp_hit_q, rsp_hit_d;
  logic               mreq_q, mreq_d;
  logic [LINE_AW-1:0] maddr_q;
  logic               wb_q, wb_d, wb_ld;
  logic [LINE_AW-1:0] wb_addr_q;
  logic [LW-1:0]      wb_data_q;

  vc_store #(.ENTRIES(ENTRIES), .AW(LINE_AW), .LW(LW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (st_wr_en),
    .wr_idx    (st_wr_idx),
    .wr_addr   (ev_addr),
    .wr_data   (ev_data),
    .wr_dirty  (ev_dirty),
    .clr_en    (st_clr_en),
    .clr_idx   (st_clr_idx),
    .ent_valid (ent_valid),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .ent_dirty (ent_dirty)
  );

  vc_match #(.ENTRIES(ENTRIES), .AW(LINE_AW)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_valid (ent_valid),
    .ent_addr  (ent_addr),
    .key       (lk_addr),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  vc_age #(.ENTRIES(ENTRIES)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (touch),
    .touch_idx (touch_idx),
    .ent_valid (ent_valid),
    .vict_idx  (vict_idx),
    .vict_free (vict_free)
  );

  assign accept = lk_valid && (state_q == VC_IDLE);

  // Next-state process
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    rsp_ld      = 1'b0;
    rsp_line_d  = rsp_line_q;
    rsp_dirty_d = rsp_dirty_q;
    rsp_hit_d   = rsp_hit_q;
    mreq_d      = 1'b0;
    wb_d        = 1'b0;
    wb_ld       = 1'b0;
    st_wr_en    = 1'b0;
    st_wr_idx   = '0;
    st_clr_en   = 1'b0;
    st_clr_idx  = '0;
    touch       = 1'b0;
    touch_idx   = '0;

    unique case (state_q)
      VC_IDLE: begin
        if (accept) begin
          if (hit) begin
            // Swap: hand out the hit line, refill its slot with the eviction.
            state_d     = VC_HIT_WAIT;
            cnt_d       = CW'(HIT_LAT - 2);
            rsp_ld      = 1'b1;
            rsp_line_d  = ent_data[hit_idx];
            rsp_dirty_d = ent_dirty[hit_idx];
            rsp_hit_d   = 1'b1;
            st_wr_en    = ev_valid;
            st_wr_idx   = hit_idx;
            st_clr_en   = !ev_valid;
            st_clr_idx  = hit_idx;
            touch       = ev_valid;
            touch_idx   = hit_idx;
          end else begin
            state_d   = VC_MISS_WAIT;
            mreq_d    = 1'b1;
            st_wr_en  = ev_valid;
            st_wr_idx = vict_idx;
            touch     = ev_valid;
            touch_idx = vict_idx;
            wb_ld     = ev_valid && !vict_free;
            wb_d      = ev_valid && !vict_free && ent_dirty[vict_idx];
          end
        end
      end
      VC_HIT_WAIT: begin
        if (cnt_q == '0) state_d = VC_RESP;
        else             cnt_d   = cnt_q - 1'b1;
      end
      VC_MISS_WAIT: begin
        if (mem_rd_valid) begin
          state_d     = VC_RESP;
          rsp_ld      = 1'b1;
          rsp_line_d  = mem_rd_data;
          rsp_dirty_d = 1'b0;
          rsp_hit_d   = 1'b0;
        end
      end
      VC_RESP: state_d = VC_IDLE;
      default: state_d = VC_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VC_IDLE;
      cnt_q   <= '0;
      mreq_q  <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mreq_q  <= mreq_d;
      wb_q    <= wb_d;
    end
  end

  // Data registers, enabled explicitly
  always_ff @(posedge clk) begin
    if (rsp_ld) begin
      rsp_line_q  <= rsp_line_d;
      rsp_dirty_q <= rsp_dirty_d;
      rsp_hit_q   <= rsp_hit_d;
    end
    if (accept) begin
      maddr_q <= lk_addr;
    end
    if (wb_ld) begin
      wb_addr_q <= ent_addr[vict_idx];
      wb_data_q <= ent_data[vict_idx];
    end
  end

  assign lk_ready    = (state_q == VC_IDLE);
  assign rsp_valid   = (state_q == VC_RESP);
  assign rsp_hit     = rsp_hit_q;
  assign rsp_dirty   = rsp_dirty_q;
  assign rsp_data    = rsp_line_q;
  assign mem_rd_req  = mreq_q;
  assign mem_rd_addr = maddr_q;
  assign wb_valid    = wb_q;
  assign wb_addr     = wb_addr_q;
  assign wb_data     = wb_data_q;

  AST_REQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req) else $error("read request longer than one cycle"); // R5

  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == VC_HIT_WAIT) |-> (!mem_rd_req && !wb_valid)) else $error("hit touched memory"); // R3

  AST_WB_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> mem_rd_req) else $error("write-back outside a miss"); // R7

  AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !lk_ready) else $error("response while ready"); // R9

  AST_RSP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (lk_ready && !rsp_valid)) else $error("not idle after response"); // R9

endmodule

// File: tb/victim_buffer_test.sv
module victim_buffer_test;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 4;
  localparam int WORDS      = 2;
  localparam int DATA_W     = 32;
  localparam int AW         = 28;
  localparam int HIT_LAT    = 4;
  localparam int LW         = WORDS * DATA_W;
  localparam int MEM_LAT    = 6;

  logic          clk, rst_n;
  logic          lk_valid, lk_ready;
  logic [AW-1:0] lk_addr;
  logic          ev_valid, ev_dirty;
  logic [AW-1:0] ev_addr;
  logic [LW-1:0] ev_data;
  logic          rsp_valid, rsp_hit, rsp_dirty;
  logic [LW-1:0] rsp_data;
  logic          mem_rd_req, mem_rd_valid;
  logic [AW-1:0] mem_rd_addr;
  logic [LW-1:0] mem_rd_data;
  logic          wb_valid;
  logic [AW-1:0] wb_addr;
  logic [LW-1:0] wb_data;

  victim_buffer #(.ENTRIES(ENTRIES), .WORDS(WORDS), .DATA_W(DATA_W),
                  .LINE_AW(AW), .HIT_LAT(HIT_LAT)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_dirty(ev_dirty), .ev_data(ev_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [AW-1:0] addr;
    logic [LW-1:0] data;
    logic          dirty;
    logic          hit;
    int            at;
  } exp_t;

  exp_t rsp_q[$];
  exp_t mrq_q[$];
  exp_t wb_q[$];

  // Reference contents
  logic          m_valid [ENTRIES];
  logic [AW-1:0] m_addr  [ENTRIES];
  logic [LW-1:0] m_data  [ENTRIES];
  logic          m_dirty [ENTRIES];
  int            m_stamp [ENTRIES];
  int            stamp_ctr = 0;

  function automatic logic [LW-1:0] mem_line(input logic [AW-1:0] a);
    return {32'(a) ^ 32'hC0DE_0000, 32'(a) + 32'h0101_0101};
  endfunction

  function automatic logic [LW-1:0] ev_line(input logic [AW-1:0] a, input logic d);
    return {32'(a) + 32'h5A5A_0000, ~32'(a) ^ {31'd0, d}};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model
  logic [AW-1:0] mem_a;
  initial begin
    mem_rd_valid = 1'b0;
    mem_rd_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_req) begin
        mem_a = mem_rd_addr;
        repeat (MEM_LAT - 1) @(negedge clk);
        mem_rd_data  = mem_line(mem_a);
        mem_rd_valid = 1'b1;
        @(negedge clk);
        mem_rd_valid = 1'b0;
      end
    end
  end

  // Monitor: pops expectations as the design produces results
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (rsp_valid) begin
          if (rsp_q.size() == 0) begin
            chk(0, "R9", "unexpected response", LW'(rsp_data), '0);
          end else begin
            e = rsp_q.pop_front();
            chk(rsp_hit == e.hit, e.hit ? "R3" : "R5", "rsp_hit", LW'(rsp_hit), LW'(e.hit));
            chk(rsp_data == e.data, e.hit ? "R4" : "R5", "rsp_data", rsp_data, e.data);
            chk(rsp_dirty == e.dirty, e.hit ? "R4" : "R5", "rsp_dirty", LW'(rsp_dirty), LW'(e.dirty));
            if (e.at >= 0)
              chk(cyc == e.at, "R3", "hit latency cycle", LW'(cyc), LW'(e.at));
          end
        end
        if (mem_rd_req) begin
          if (mrq_q.size() == 0) begin
            chk(0, "R3", "unexpected memory read", LW'(mem_rd_addr), '0);
          end else begin
            e = mrq_q.pop_front();
            chk(mem_rd_addr == e.addr, "R5", "mem_rd_addr", LW'(mem_rd_addr), LW'(e.addr));
            chk(cyc == e.at, "R5", "mem_rd_req cycle", LW'(cyc), LW'(e.at));
          end
        end
        if (wb_valid) begin
          if (wb_q.size() == 0) begin
            chk(0, "R7", "unexpected write-back", LW'(wb_addr), '0);
          end else begin
            e = wb_q.pop_front();
            chk(wb_addr == e.addr, "R7", "wb_addr", LW'(wb_addr), LW'(e.addr));
            chk(wb_data == e.data, "R7", "wb_data", wb_data, e.data);
            chk(cyc == e.at, "R7", "wb cycle", LW'(cyc), LW'(e.at));
          end
        end
      end
    end
  end

  function automatic bit in_model(input logic [AW-1:0] a);
    for (int i = 0; i < ENTRIES; i++)
      if (m_valid[i] && m_addr[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  // Driver: updates the reference, pushes expectations, drives one lookup.
  // With jam set, keeps presenting another lookup while the block is busy.
  task automatic do_lookup(input logic [AW-1:0] a, input bit evv,
                           input logic [AW-1:0] ea, input bit ed, input bit jam);
    exp_t e;
    int   slot;
    int   c;
    logic [AW-1:0] jam_addr;
    @(negedge clk);
    while (!lk_ready) @(negedge clk);
    c    = cyc;
    slot = -1;
    for (int i = 0; i < ENTRIES; i++)
      if (slot < 0 && m_valid[i] && m_addr[i] == a) slot = i;
    if (slot >= 0) begin
      e = '{addr: a, data: m_data[slot], dirty: m_dirty[slot], hit: 1'b1, at: c + HIT_LAT};
      rsp_q.push_back(e);
      if (evv) begin
        m_addr[slot] = ea; m_data[slot] = ev_line(ea, ed);
        m_dirty[slot] = ed; m_stamp[slot] = ++stamp_ctr;
      end else begin
        m_valid[slot] = 1'b0;
      end
    end else begin
      e = '{addr: a, data: mem_line(a), dirty: 1'b0, hit: 1'b0, at: -1};
      rsp_q.push_back(e);
      e = '{addr: a, data: '0, dirty: 1'b0, hit: 1'b0, at: c + 1};
      mrq_q.push_back(e);
      if (evv) begin
        for (int i = 0; i < ENTRIES; i++)
          if (slot < 0 && !m_valid[i]) slot = i;
        if (slot < 0) begin
          slot = 0;
          for (int i = 1; i < ENTRIES; i++)
            if (m_stamp[i] < m_stamp[slot]) slot = i;
          if (m_dirty[slot]) begin
            e = '{addr: m_addr[slot], data: m_data[slot], dirty: 1'b1, hit: 1'b0, at: c + 1};
            wb_q.push_back(e);
          end
        end
        m_valid[slot] = 1'b1; m_addr[slot] = ea; m_data[slot] = ev_line(ea, ed);
        m_dirty[slot] = ed; m_stamp[slot] = ++stamp_ctr;
      end
    end
    lk_valid = 1'b1; lk_addr = a;
    ev_valid = evv;  ev_addr = ea; ev_dirty = ed; ev_data = ev_line(ea, ed);
    @(negedge clk);
    if (jam) begin
      jam_addr = 28'h0BAD_BAD;
      for (int i = 0; i < ENTRIES; i++) if (m_valid[i]) jam_addr = m_addr[i];
      lk_addr = jam_addr; ev_valid = 1'b1; ev_addr = 28'h0999_999; ev_dirty = 1'b1;
      while (!rsp_valid) @(negedge clk);
    end
    lk_valid = 1'b0; ev_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!lk_ready || rsp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [AW-1:0] pool [12];
    logic [AW-1:0] a, ea;
    for (int i = 0; i < ENTRIES; i++) begin
      m_valid[i] = 1'b0; m_stamp[i] = 0; m_addr[i] = '0; m_data[i] = '0; m_dirty[i] = 1'b0;
    end
    rst_n = 1'b0; lk_valid = 1'b0; lk_addr = '0;
    ev_valid = 1'b0; ev_addr = '0; ev_dirty = 1'b0; ev_data = '0;
    repeat (2) @(negedge clk);
    // R1: outputs during reset
    chk(lk_ready == 1'b1, "R1", "lk_ready in reset", LW'(lk_ready), LW'(1));
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", LW'(rsp_valid), '0);
    chk(mem_rd_req == 1'b0, "R1", "mem_rd_req in reset", LW'(mem_rd_req), '0);
    chk(wb_valid == 1'b0, "R1", "wb_valid in reset", LW'(wb_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lk_ready == 1'b1 && !rsp_valid && !wb_valid, "R1", "idle after reset",
        LW'({lk_ready, rsp_valid, wb_valid}), LW'(3'b100));

    // R1/R5/R6: misses on an empty store; dirty then clean eviction stored
    do_lookup(28'h0001000, 1, 28'h0002000, 1, 0);
    do_lookup(28'h0003000, 1, 28'h0004000, 0, 0);
    // R3/R4: hit on a dirty line, swap in a clean one
    do_lookup(28'h0002000, 1, 28'h0001000, 0, 0);
    // R4: handed-out line now misses; R6 clean entry survives
    do_lookup(28'h0002000, 0, 28'h0, 0, 0);
    // R4: swapped-in line hits; R10: no eviction empties the slot
    do_lookup(28'h0001000, 0, 28'h0, 0, 0);
    do_lookup(28'h0001000, 0, 28'h0, 0, 0);
    // R2: differs only in the top bit
    do_lookup(28'h8004000, 0, 28'h0, 0, 0);
    do_lookup(28'h0004000, 1, 28'h0004000 ^ 28'h0000001, 1, 0);
    // fill: R6 lowest free slot, then R7 displacement by age
    do_lookup(28'h0010000, 1, 28'h0011000, 1, 0);
    do_lookup(28'h0012000, 1, 28'h0013000, 0, 0);
    do_lookup(28'h0014000, 1, 28'h0015000, 1, 0);
    do_lookup(28'h0016000, 1, 28'h0017000, 0, 0);
    // R8: swap refreshes an entry's age, so a different one is displaced
    do_lookup(28'h0011000, 1, 28'h0018000, 1, 0);
    do_lookup(28'h0019000, 1, 28'h001A000, 0, 0);
    do_lookup(28'h001B000, 1, 28'h001C000, 1, 0);
    do_lookup(28'h001D000, 1, 28'h001E000, 0, 0);
    // R9: lookups presented while busy are ignored
    do_lookup(28'h0020000, 1, 28'h0021000, 1, 1);
    do_lookup(28'h0018000, 1, 28'h0022000, 0, 1);
    wait_idle();
    for (int i = 0; i < ENTRIES; i++)
      if (m_valid[i]) do_lookup(m_addr[i], 1, m_addr[i] ^ 28'h0400000, m_dirty[i], 0);

    // Seeded mix over a small address pool
    for (int i = 0; i < 12; i++) pool[i] = AW'(28'h0100000 + i * 28'h0000100);
    seed = 7;
    for (int n = 0; n < 120; n++) begin
      int k;
      seed = seed * 1103515245 + 12345;
      a = pool[(seed >>> 8) & 32'h7fff % 12];
      a = pool[((seed >>> 8) & 32'h7fff) % 12];
      k = (seed >>> 4) & 32'hff;
      ea = '0;
      for (int j = 0; j < 12; j++) begin
        logic [AW-1:0] cand;
        cand = pool[(k + j) % 12];
        if (ea == '0 && cand != a && !in_model(cand)) ea = cand;
      end
      do_lookup(a, (ea != '0) && seed[20], ea, seed[21], seed[22] & seed[23]);
    end

    wait_idle();
    chk(rsp_q.size() == 0, "R5", "responses outstanding", LW'(rsp_q.size()), '0);
    chk(wb_q.size() == 0, "R7", "write-backs outstanding", LW'(wb_q.size()), '0);
    chk(mrq_q.size() == 0, "R5", "reads outstanding", LW'(mrq_q.size()), '0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule